// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block holds the mixer and control registers of an audio codec as a bank of 16-bit words behind a simple host port. The host presents a byte address, an access size, a write word and read or write strobes. Only word-sized accesses reach the registers. Every register has its own write rule. Some words keep only certain bits. Some are fixed and cannot be written. The sample-rate words accept writes only while a feature bit in the extended control word allows it.

On reset, and on any word write to offset 0x00, every register is loaded with its default value. The three volume words are decoded into mute and left/right attenuation fields on dedicated outputs. A one-cycle pulse per rate register tells a downstream rate generator that the register was loaded with a new value.

Top module: `codec_mixer_regs`

## Requirements
- R1: After reset, the registers hold these values: 0x26=0x000F, 0x28=0x0809, 0x2A=0x0009, rate words 0x2C/0x2E/0x30/0x32/0x34=0xBB80, 0x7C=0x8384, 0x7E=0x7600, 0x02=0x8000, 0x18=0x8808, 0x1C=0x8808. Every other register holds 0.
- R2: Only accesses with size code 1 (word) take effect. Size 0 (byte) and size 2 (dword) reads return 0xFFFF, and writes of those sizes change nothing.
- R3: A word write to offset 0x00 reloads every register with its R1 default.
- R4: A write to 0x02 is stored ANDed with 0xBF3F, a write to 0x18 is stored ANDed with 0x9F1F, and a write to 0x1C is stored ANDed with 0x8F0F. The outputs come from bit 15 (mute), bits 13:8/12:8/11:8 (left) and bits 5:0/4:0/3:0 (right) of these stored words.
- R5: A write to 0x1A keeps only bits 10:8 and 2:0. All other bits are stored as zero.
- R6: A write to 0x26 stores the written value with bit 15 and bits 3:0 cleared, then ORed with the previously stored bits 3:0.
- R7: Writes to 0x2C and 0x32 take effect only while bit 0 of 0x2A is set. Writes to 0x34 take effect only while bit 3 of 0x2A is set. Otherwise the write is dropped.
- R8: A write to 0x2A with bit 0 clear forces 0xBB80 into 0x2C and 0x32. A write with bit 3 clear forces 0xBB80 into 0x34. The written value is stored in 0x2A.
- R9: Offsets 0x04 to 0x16, 0x1E, 0x20, 0x22, 0x28, 0x7C and 0x7E ignore writes.
- R10: Any other even offset below 0x100 stores the written word as is. Offsets at or above 0x100 read 0xFFFF and ignore writes.
- R11: rate_upd bit 0 (0x2C), bit 1 (0x32) and bit 2 (0x34) is high for exactly the one cycle after a write, or a forced load from R8, loads that register. It stays low for a dropped write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| addr | input | 9 | Byte address |
| size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Read word, registered |
| master_mute | output | 1 | Master mute flag |
| master_left | output | 6 | Master left attenuation |
| master_right | output | 6 | Master right attenuation |
| pcm_mute | output | 1 | PCM-out mute flag |
| pcm_left | output | 5 | PCM-out left attenuation |
| pcm_right | output | 5 | PCM-out right attenuation |
| rec_mute | output | 1 | Record gain mute flag |
| rec_left | output | 4 | Record gain left |
| rec_right | output | 4 | Record gain right |
| rate_upd | output | 3 | Rate-change pulses: DAC, ADC, mic |

## Verification
Every write is committed at the first rising edge after it is driven. The volume outputs and the rate_upd pulse change at that same edge. A read result is registered at the edge that samples rd_en, so it appears one cycle after the request. The bench drives all strobes on the falling edge. It checks the pulses and volume fields at the falling edge that follows the write edge, and reads rdata one falling edge after raising rd_en. A pulse is therefore checked in its only high cycle, and a read is never sampled early.

// File: rtl/codec_mixer_regs.sv
module codec_mixer_regs #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [8:0]    addr,
  input  logic [1:0]    size,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          master_mute,
  output logic [5:0]    master_left,
  output logic [5:0]    master_right,
  output logic          pcm_mute,
  output logic [4:0]    pcm_left,
  output logic [4:0]    pcm_right,
  output logic          rec_mute,
  output logic [3:0]    rec_left,
  output logic [3:0]    rec_right,
  output logic [2:0]    rate_upd
);
  localparam int IW   = AW - 2;
  localparam int NREG = 1 << IW;
  localparam logic [DW-1:0] RATE48K = 16'hBB80;

  logic [DW-1:0] mem [NREG];
  logic [IW-1:0] idx;
  logic          word_ok, wr_word;

  assign idx     = addr[IW:1];
  assign word_ok = (size == 2'd1) && !addr[0] && !addr[AW-1];
  assign wr_word = wr_en && word_ok;

  function automatic logic [DW-1:0] dflt(input int i);
    case (i)
      8'h01:                         dflt = 16'h8000;
      8'h0C, 8'h0E:                  dflt = 16'h8808;
      8'h13:                         dflt = 16'h000F;
      8'h14:                         dflt = 16'h0809;
      8'h15:                         dflt = 16'h0009;
      8'h16, 8'h17, 8'h18, 8'h19,
      8'h1A:                         dflt = RATE48K;
      8'h3E:                         dflt = 16'h8384;
      8'h3F:                         dflt = 16'h7600;
      default:                       dflt = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= dflt(i);
      rate_upd <= '0;
    end else begin
      rate_upd <= '0;
      if (wr_word) begin
        case (idx)
          7'h00: for (int i = 0; i < NREG; i++) mem[i] <= dflt(i);
          7'h01: mem[idx] <= wdata & 16'hBF3F;
          7'h0C: mem[idx] <= wdata & 16'h9F1F;
          7'h0E: mem[idx] <= wdata & 16'h8F0F;
          7'h0D: mem[idx] <= wdata & 16'h0707;
          7'h13: mem[idx] <= (wdata & 16'h7FF0) | (mem[idx] & 16'h000F);
          7'h15: begin
            if (!wdata[0]) begin
              mem[7'h16]  <= RATE48K;
              mem[7'h19]  <= RATE48K;
              rate_upd[0] <= 1'b1;
              rate_upd[1] <= 1'b1;
            end
            if (!wdata[3]) begin
              mem[7'h1A]  <= RATE48K;
              rate_upd[2] <= 1'b1;
            end
            mem[idx] <= wdata;
          end
          7'h16: if (mem[7'h15][0]) begin mem[idx] <= wdata; rate_upd[0] <= 1'b1; end
          7'h19: if (mem[7'h15][0]) begin mem[idx] <= wdata; rate_upd[1] <= 1'b1; end
          7'h1A: if (mem[7'h15][3]) begin mem[idx] <= wdata; rate_upd[2] <= 1'b1; end
          7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h07, 7'h08, 7'h09, 7'h0A, 7'h0B,
          7'h0F, 7'h10, 7'h11, 7'h14, 7'h3E, 7'h3F: ;
          default: mem[idx] <= wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= word_ok ? mem[idx] : 16'hFFFF;
  end

  assign master_mute  = mem[7'h01][15];
  assign master_left  = mem[7'h01][13:8];
  assign master_right = mem[7'h01][5:0];
  assign pcm_mute     = mem[7'h0C][15];
  assign pcm_left     = mem[7'h0C][12:8];
  assign pcm_right    = mem[7'h0C][4:0];
  assign rec_mute     = mem[7'h0E][15];
  assign rec_left     = mem[7'h0E][11:8];
  assign rec_right    = mem[7'h0E][3:0];

  AST_VOL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[7'h01] & 16'h40C0) == 16'h0) else $error("master reserved bits set"); // R4

  AST_RSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[7'h0D] & 16'hF8F8) == 16'h0) else $error("record select reserved bits set"); // R5

  AST_PDN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_ok && idx == 7'h13) |=> mem[7'h13][3:0] == $past(mem[7'h13][3:0]))
    else $error("power-down low nibble changed"); // R6

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_ok && idx == 7'h3E) |=> $stable(mem[7'h3E])) else $error("vendor id written"); // R9

  AST_MIC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_ok && idx == 7'h15 && !wdata[3]) |=> mem[7'h1A] == RATE48K && rate_upd[2])
    else $error("mic rate not forced"); // R8

  AST_DROP_NOPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_ok && idx == 7'h16 && !mem[7'h15][0]) |=> !rate_upd[0] && $stable(mem[7'h16]))
    else $error("gated rate write taken"); // R7
endmodule

// File: tb/sim_codec_mixer_regs.sv
module sim_codec_mixer_regs;
  logic clk = 0, rst_n = 0;
  logic [8:0] addr = '0;
  logic [1:0] size = 2'd1;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic master_mute, pcm_mute, rec_mute;
  logic [5:0] master_left, master_right;
  logic [4:0] pcm_left, pcm_right;
  logic [3:0] rec_left, rec_right;
  logic [2:0] rate_upd;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  codec_mixer_regs u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
    @(negedge clk); addr = a; wdata = d; size = sz; wr_en = 1;
    @(negedge clk); wr_en = 0; size = 2'd1;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] q, input logic [1:0] sz = 2'd1);
    @(negedge clk); addr = a; size = sz; rd_en = 1;
    @(negedge clk); q = rdata; rd_en = 0; size = 2'd1;
  endtask

  task automatic t_r1_defaults();
    logic [15:0] q;
    rd(9'h026, q); chk("R1", q, 16'h000F);
    rd(9'h028, q); chk("R1", q, 16'h0809);
    rd(9'h02A, q); chk("R1", q, 16'h0009);
    rd(9'h02E, q); chk("R1", q, 16'hBB80);
    rd(9'h034, q); chk("R1", q, 16'hBB80);
    rd(9'h07C, q); chk("R1", q, 16'h8384);
    rd(9'h07E, q); chk("R1", q, 16'h7600);
    rd(9'h018, q); chk("R1", q, 16'h8808);
    rd(9'h040, q); chk("R1", q, 16'h0000);
    chk("R1 master_mute", {15'd0, master_mute}, 16'h1);
  endtask

  task automatic t_r4_volume();
    wr(9'h002, 16'hFFFF);
    chk("R4 master", {master_mute, 3'd0, master_left, master_right}, 16'h8FFF);
    wr(9'h018, 16'h7FFF);
    chk("R4 pcm", {pcm_mute, 5'd0, pcm_left, pcm_right}, 16'h03FF);
    wr(9'h01C, 16'hFFFF);
    chk("R4 rec", {rec_mute, 7'd0, rec_left, rec_right}, 16'h80FF);
    begin logic [15:0] q; rd(9'h002, q); chk("R4 stored", q, 16'hBF3F); end
  endtask

  task automatic t_r5_r6();
    logic [15:0] q;
    wr(9'h01A, 16'hFFFF); rd(9'h01A, q); chk("R5", q, 16'h0707);
    wr(9'h026, 16'hFFFF); rd(9'h026, q); chk("R6", q, 16'h7FFF);
    wr(9'h026, 16'h0000); rd(9'h026, q); chk("R6", q, 16'h000F);
  endtask

  task automatic t_r7_r8_r11();
    logic [15:0] q;
    wr(9'h02C, 16'h5622); chk("R11 dac", {13'd0, rate_upd}, 16'h1);
    rd(9'h02C, q); chk("R7 open", q, 16'h5622);
    wr(9'h02A, 16'h0000); chk("R11 force", {13'd0, rate_upd}, 16'h7);
    rd(9'h02C, q); chk("R8 dac", q, 16'hBB80);
    rd(9'h032, q); chk("R8 adc", q, 16'hBB80);
    rd(9'h02A, q); chk("R8 stored", q, 16'h0000);
    wr(9'h032, 16'h1F40); chk("R11 drop", {13'd0, rate_upd}, 16'h0);
    rd(9'h032, q); chk("R7 gated", q, 16'hBB80);
    wr(9'h02A, 16'h0001); chk("R11 mic force", {13'd0, rate_upd}, 16'h4);
    wr(9'h032, 16'h1F40); chk("R11 adc", {13'd0, rate_upd}, 16'h2);
    rd(9'h032, q); chk("R7 adc", q, 16'h1F40);
    wr(9'h034, 16'h2B11); chk("R11 mic drop", {13'd0, rate_upd}, 16'h0);
    rd(9'h034, q); chk("R7 mic", q, 16'hBB80);
  endtask

  task automatic t_r9_r10_r2();
    logic [15:0] q;
    wr(9'h07C, 16'h1234); rd(9'h07C, q); chk("R9 id", q, 16'h8384);
    wr(9'h010, 16'hAAAA); rd(9'h010, q); chk("R9 ro", q, 16'h0000);
    wr(9'h028, 16'h0000); rd(9'h028, q); chk("R9 extid", q, 16'h0809);
    wr(9'h040, 16'hCAFE); rd(9'h040, q); chk("R10 store", q, 16'hCAFE);
    rd(9'h100, q); chk("R10 oor read", q, 16'hFFFF);
    wr(9'h100, 16'h0000); rd(9'h040, q); chk("R10 oor write", q, 16'hCAFE);
    rd(9'h040, q, 2'd0); chk("R2 byte read", q, 16'hFFFF);
    rd(9'h040, q, 2'd2); chk("R2 dword read", q, 16'hFFFF);
    wr(9'h040, 16'h1111, 2'd2); rd(9'h040, q); chk("R2 dword write", q, 16'hCAFE);
    wr(9'h000, 16'h0000, 2'd0); rd(9'h040, q); chk("R2 byte write", q, 16'hCAFE);
  endtask

  task automatic t_r3_reload();
    logic [15:0] q;
    wr(9'h000, 16'h1234);
    rd(9'h040, q); chk("R3", q, 16'h0000);
    rd(9'h002, q); chk("R3", q, 16'h8000);
    rd(9'h02A, q); chk("R3", q, 16'h0009);
    rd(9'h032, q); chk("R3", q, 16'hBB80);
    chk("R3 pcm out", {pcm_mute, 5'd0, pcm_left, pcm_right}, 16'h8108);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_r1_defaults();
    t_r4_volume();
    t_r5_r6();
    t_r7_r8_r11();
    t_r9_r10_r2();
    t_r3_reload();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule